// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Tick Source

This block is a 16-bit timer/counter with three mutually exclusive modes. The count sits in two byte-wide registers, and a second byte pair serves as the capture destination or the reload source. In capture mode the counter runs freely. A falling edge on the trigger pin snapshots the count. In auto-reload mode the counter is reloaded from the byte pair when it wraps, or on a trigger edge. In baud mode the counter advances on a faster clock enable and emits a one-cycle baud tick each time it wraps and reloads.

Software reaches the block through a small synchronous register bus with a combinational read port. Counting in capture and auto-reload modes follows a machine-cycle tick. One control bit makes those modes count falling edges on an external count pin instead. Both pins are sampled only on machine-cycle ticks.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset every register reads 0x00, and the overflow flag, the external flag and the baud tick are all low.
- R2: Register addresses are: 0 count low, 1 count high, 2 reload low, 3 reload high, 4 control. Any other address reads 0x00. Control bits are: bit0 run, bit1 external count source, bits3:2 mode (0 capture, 1 auto-reload, 2 baud, 3 treated as capture), bit4 trigger enable, bit5 overflow flag, bit6 external flag, bit7 reads 0.
- R3: In capture and auto-reload modes with the internal source selected, the count rises by one for each machine-cycle tick while run is 1. With run at 0 the count does not change.
- R4: With the external source selected, the count pin is sampled on each tick. A sample of 0 that follows a sample of 1 adds one to the count.
- R5: In capture mode an increment from 0xFFFF gives 0x0000 and sets the overflow flag.
- R6: In capture mode with trigger enable set, a trigger falling edge copies the count held before that cycle's increment into the reload pair and sets the external flag. The trigger pin is sampled on ticks, as in R4.
- R7: In auto-reload mode an increment from 0xFFFF loads the reload pair into the count and sets the overflow flag.
- R8: In auto-reload mode with trigger enable set, a trigger falling edge loads the reload pair into the count, whether or not run is set, and sets the external flag.
- R9: In baud mode, while run is 1, the count rises on every cycle in which the baud clock enable is high, and the machine-cycle tick has no effect. A wrap from 0xFFFF reloads the count and raises the baud tick for exactly the following cycle. A wrap never sets the overflow flag.
- R10: With trigger enable clear, trigger edges change neither the reload pair nor the count nor the external flag.
- R11: A bus write to a count byte takes effect in place of any increment or reload in the same cycle.
- R12: Writing the control register with a 0 in a flag bit clears that flag. A 1 leaves it unchanged and cannot set it. A hardware set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Machine-cycle tick enable |
| baud_clk_i | input | 1 | Fast clock enable used in baud mode |
| cnt_pin_i | input | 1 | External event input |
| trig_pin_i | input | 1 | External capture/reload trigger |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| ovf_flag_o | output | 1 | Overflow flag |
| ext_flag_o | output | 1 | External trigger flag |
| baud_tick_o | output | 1 | One-cycle pulse on each baud-mode wrap |

## Verification
A corrupted count or reload byte shows up on the next read of that address. It also shifts when the next wrap happens, so the flag or baud tick comes early or late by the size of the error. A bad edge-sample register shows up within one tick as a missing or extra increment, capture or reload. A flag logic fault appears in the control read one cycle after the wrap or trigger. A mode decode fault shows either as an overflow flag raised in baud mode or as baud ticks counted outside it.

// File: rtl/crt_pkg.sv
`timescale 1ns/1ps
package crt_pkg;

  typedef enum logic [1:0] {
    MD_CAPTURE = 2'd0,
    MD_RELOAD  = 2'd1,
    MD_BAUD    = 2'd2,
    MD_RSVD    = 2'd3
  } crt_mode_e;

  // register addresses
  localparam int A_CNT_LO = 0;
  localparam int A_CNT_HI = 1;
  localparam int A_RLD_LO = 2;
  localparam int A_RLD_HI = 3;
  localparam int A_CTRL   = 4;

  // control bit positions
  localparam int CB_RUN  = 0;
  localparam int CB_EXT  = 1;
  localparam int CB_MODE = 2;
  localparam int CB_TEN  = 4;
  localparam int CB_OVF  = 5;
  localparam int CB_EXF  = 6;

  // reserved encoding behaves as capture
  function automatic crt_mode_e mode_decode(input logic [1:0] raw);
    if (raw == 2'd1) return MD_RELOAD;
    if (raw == 2'd2) return MD_BAUD;
    return MD_CAPTURE;
  endfunction

  // sticky flag update: hardware set dominates, write of 0 clears
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic wr, input logic wbit);
    if (set) return 1'b1;
    if (wr)  return cur & wbit;
    return cur;
  endfunction

endpackage

// File: rtl/crt_edge_det.sv
`timescale 1ns/1ps
module crt_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic pin,
  output logic fall_o
);
  logic last_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         last_q <= 1'b0;
    else if (sample_en) last_q <= pin;
  end

  assign fall_o = sample_en & last_q & ~pin;
endmodule

// File: rtl/crt_ctrl.sv
`timescale 1ns/1ps
module crt_ctrl
  import crt_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic [BW-1:0] wdata,
  input  logic          set_ovf,
  input  logic          set_exf,
  output logic          run,
  output logic          ext_src,
  output crt_mode_e     mode,
  output logic          trig_en,
  output logic          ovf_flag,
  output logic          exf_flag,
  output logic [BW-1:0] ctrl_rd
);
  logic [1:0] mode_raw_q;
  logic       run_q, ext_q, ten_q, ovf_q, exf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      ext_q      <= 1'b0;
      ten_q      <= 1'b0;
      mode_raw_q <= 2'd0;
      ovf_q      <= 1'b0;
      exf_q      <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        run_q      <= wdata[CB_RUN];
        ext_q      <= wdata[CB_EXT];
        ten_q      <= wdata[CB_TEN];
        mode_raw_q <= wdata[CB_MODE +: 2];
      end
      ovf_q <= flag_next(ovf_q, set_ovf, ctrl_wr, wdata[CB_OVF]);
      exf_q <= flag_next(exf_q, set_exf, ctrl_wr, wdata[CB_EXF]);
    end
  end

  assign run      = run_q;
  assign ext_src  = ext_q;
  assign trig_en  = ten_q;
  assign mode     = mode_decode(mode_raw_q);
  assign ovf_flag = ovf_q;
  assign exf_flag = exf_q;

  always_comb begin
    ctrl_rd                 = '0;
    ctrl_rd[CB_RUN]         = run_q;
    ctrl_rd[CB_EXT]         = ext_q;
    ctrl_rd[CB_MODE +: 2]   = mode_raw_q;
    ctrl_rd[CB_TEN]         = ten_q;
    ctrl_rd[CB_OVF]         = ovf_q;
    ctrl_rd[CB_EXF]         = exf_q;
  end
endmodule

// File: rtl/crt_counter.sv
`timescale 1ns/1ps
module crt_counter #(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cnt_wr,     // [0] low byte, [1] high byte
  input  logic [1:0]    rld_wr,
  input  logic [BW-1:0] wdata,
  input  logic          inc_en,
  input  logic          reload_now,
  input  logic          wrap_reload,
  input  logic          cap_now,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] rld,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q, rld_q, cnt_d, rld_d;
  logic          sw_cnt;

  function automatic logic all_ones(input logic [CW-1:0] v);
    return &v;
  endfunction

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return v + CW'(1);
  endfunction

  assign sw_cnt = |cnt_wr;
  assign wrap_o = inc_en & ~sw_cnt & ~reload_now & all_ones(cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (sw_cnt) begin
      for (int b = 0; b < 2; b++)
        if (cnt_wr[b]) cnt_d[b*BW +: BW] = wdata;
    end else if (reload_now) begin
      cnt_d = rld_q;
    end else if (wrap_o) begin
      cnt_d = wrap_reload ? rld_q : '0;
    end else if (inc_en) begin
      cnt_d = bump(cnt_q);
    end
  end

  generate
    for (genvar g = 0; g < 2; g++) begin : g_rld
      always_comb begin
        if (rld_wr[g])    rld_d[g*BW +: BW] = wdata;
        else if (cap_now) rld_d[g*BW +: BW] = cnt_q[g*BW +: BW];
        else              rld_d[g*BW +: BW] = rld_q[g*BW +: BW];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
    end
  end

  assign cnt = cnt_q;
  assign rld = rld_q;
endmodule

// File: rtl/cap_reload_timer.sv
`timescale 1ns/1ps
module cap_reload_timer
  import crt_pkg::*;
#(
  parameter int BW = 8,
  parameter int AW = 3,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          baud_clk_i,
  input  logic          cnt_pin_i,
  input  logic          trig_pin_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] rdata_o,
  output logic          ovf_flag_o,
  output logic          ext_flag_o,
  output logic          baud_tick_o
);
  // named internal events
  logic          cnt_fall, trig_fall, trig_act;
  logic          cap_ev, trig_rel, wrap_ev, baud_ev;
  logic          inc_en, is_baud, is_reload, is_capture;
  logic          run, ext_src, trig_en, ctrl_wr;
  logic [1:0]    cnt_wr, rld_wr;
  logic [CW-1:0] cnt, rld;
  logic [BW-1:0] ctrl_rd;
  logic          baud_q;
  crt_mode_e     mode;

  assign cnt_wr[0] = wr_en_i && (addr_i == AW'(A_CNT_LO));
  assign cnt_wr[1] = wr_en_i && (addr_i == AW'(A_CNT_HI));
  assign rld_wr[0] = wr_en_i && (addr_i == AW'(A_RLD_LO));
  assign rld_wr[1] = wr_en_i && (addr_i == AW'(A_RLD_HI));
  assign ctrl_wr   = wr_en_i && (addr_i == AW'(A_CTRL));

  crt_edge_det u_cnt_edge (
    .clk(clk), .rst_n(rst_n), .sample_en(tick_i), .pin(cnt_pin_i), .fall_o(cnt_fall)
  );

  crt_edge_det u_trig_edge (
    .clk(clk), .rst_n(rst_n), .sample_en(tick_i), .pin(trig_pin_i), .fall_o(trig_fall)
  );

  assign is_baud    = (mode == MD_BAUD);
  assign is_reload  = (mode == MD_RELOAD);
  assign is_capture = (mode == MD_CAPTURE);

  assign inc_en   = run & (is_baud ? baud_clk_i : (tick_i & (ext_src ? cnt_fall : 1'b1)));
  assign trig_act = trig_fall & trig_en;
  assign cap_ev   = trig_act & is_capture;
  assign trig_rel = trig_act & is_reload;
  assign baud_ev  = wrap_ev & is_baud;

  crt_ctrl #(.BW(BW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(wdata_i),
    .set_ovf(wrap_ev & ~is_baud), .set_exf(trig_act),
    .run(run), .ext_src(ext_src), .mode(mode), .trig_en(trig_en),
    .ovf_flag(ovf_flag_o), .exf_flag(ext_flag_o), .ctrl_rd(ctrl_rd)
  );

  crt_counter #(.BW(BW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .rld_wr(rld_wr), .wdata(wdata_i),
    .inc_en(inc_en), .reload_now(trig_rel), .wrap_reload(~is_capture),
    .cap_now(cap_ev), .cnt(cnt), .rld(rld), .wrap_o(wrap_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) baud_q <= 1'b0;
    else        baud_q <= baud_ev;
  end
  assign baud_tick_o = baud_q;

  always_comb begin
    case (int'(addr_i))
      A_CNT_LO: rdata_o = cnt[0  +: BW];
      A_CNT_HI: rdata_o = cnt[BW +: BW];
      A_RLD_LO: rdata_o = rld[0  +: BW];
      A_RLD_HI: rdata_o = rld[BW +: BW];
      A_CTRL:   rdata_o = ctrl_rd;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/crt_chk.sv
`timescale 1ns/1ps
module crt_chk #(
  parameter int BW = 8,
  parameter int AW = 3,
  localparam int CW = 2 * BW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          is_baud,
  input logic [1:0]    cnt_wr,
  input logic [1:0]    rld_wr,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] rld,
  input logic          wrap_ev,
  input logic          trig_act,
  input logic          trig_rel,
  input logic          cap_ev,
  input logic          ovf_flag_o,
  input logic          ext_flag_o,
  input logic          baud_tick_o,
  input logic [BW-1:0] wdata_i
);
  // R9
  baud_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick_o |-> $past(is_baud));

  // R9
  baud_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev && is_baud && !ovf_flag_o) |=> !ovf_flag_o);

  // R5
  wrap_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ev && !is_baud) |=> ovf_flag_o);

  // R6
  capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ev && rld_wr == 2'b00) |=> (rld == $past(cnt)));

  // R8
  trig_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_rel && cnt_wr == 2'b00) |=> (cnt == $past(rld)));

  // R6
  trig_sets_exf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_act |=> ext_flag_o);

  // R3
  halted_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && cnt_wr == 2'b00 && !trig_rel) |=> $stable(cnt));

  // R11
  sw_write_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr[0] |=> (cnt[BW-1:0] == $past(wdata_i)));
endmodule

bind cap_reload_timer crt_chk #(.BW(BW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .is_baud(is_baud),
  .cnt_wr(cnt_wr), .rld_wr(rld_wr), .cnt(cnt), .rld(rld),
  .wrap_ev(wrap_ev), .trig_act(trig_act), .trig_rel(trig_rel), .cap_ev(cap_ev),
  .ovf_flag_o(ovf_flag_o), .ext_flag_o(ext_flag_o), .baud_tick_o(baud_tick_o),
  .wdata_i(wdata_i)
);

// File: tb/cap_reload_timer_tb.sv
`timescale 1ns/1ps
module cap_reload_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, baud_clk_i = 1'b0, cnt_pin_i = 1'b0, trig_pin_i = 1'b1;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       ovf_flag_o, ext_flag_o, baud_tick_o;

  int nchk = 0, nerr = 0, pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  cap_reload_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .baud_clk_i(baud_clk_i),
    .cnt_pin_i(cnt_pin_i), .trig_pin_i(trig_pin_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .ovf_flag_o(ovf_flag_o), .ext_flag_o(ext_flag_o), .baud_tick_o(baud_tick_o)
  );

  always @(negedge clk) if (baud_tick_o) pulses++;

  typedef struct packed {
    logic [1:0]  md;
    logic [15:0] rld;
    logic [15:0] start;
    logic [7:0]  ncyc;
    logic [15:0] exp_cnt;
    logic        exp_ovf;
    logic [3:0]  exp_pulses;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{2'd0, 16'h0000, 16'h0010, 8'd10, 16'h0015, 1'b0, 4'd0},  // R3
    '{2'd0, 16'h0000, 16'hFFFE, 8'd6,  16'h0001, 1'b1, 4'd0},  // R5
    '{2'd1, 16'hFFF0, 16'hFFFD, 8'd10, 16'hFFF2, 1'b1, 4'd0},  // R7
    '{2'd1, 16'h1234, 16'h1000, 8'd8,  16'h1004, 1'b0, 4'd0},  // R3
    '{2'd2, 16'hFFFC, 16'hFFFC, 8'd10, 16'hFFFE, 1'b0, 4'd2}   // R9
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr_i = a;
    #2 d = rdata_o;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 3'd1, hi);
    d = {hi, lo};
  endtask

  task automatic setup(input logic [15:0] rv, input logic [15:0] cv);
    wr(3'd4, 8'h00);
    wr(3'd2, rv[7:0]); wr(3'd3, rv[15:8]);
    wr(3'd0, cv[7:0]); wr(3'd1, cv[15:8]);
  endtask

  // ticks on even cycles, baud enable every cycle
  task automatic run_cycles(input int n);
    for (int k = 0; k < n; k++) begin
      tick_i = (k % 2 == 0); baud_clk_i = 1'b1;
      @(negedge clk);
    end
    tick_i = 1'b0; baud_clk_i = 1'b0;
  endtask

  // four ticks, trigger high for three then low
  task automatic trig_seq();
    for (int k = 0; k < 4; k++) begin
      tick_i = 1'b1; trig_pin_i = (k < 3);
      @(negedge clk);
    end
    tick_i = 1'b0; trig_pin_i = 1'b1;
  endtask

  logic [15:0] v16;
  logic [7:0]  v8;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v8);
      check("R1 reg", 16'(v8), 16'h0);
    end
    check("R1 outs", {13'b0, ovf_flag_o, ext_flag_o, baud_tick_o}, 16'h0);
    // R2 unused address and control layout
    rd(3'd6, v8); check("R2 unused addr", 16'(v8), 16'h0);
    wr(3'd4, 8'h9B); rd(3'd4, v8); check("R2 ctrl readback", 16'(v8), 16'h1B);
    wr(3'd4, 8'h00);

    // vector table
    foreach (VEC[i]) begin
      setup(VEC[i].rld, VEC[i].start);
      pulses = 0;
      wr(3'd4, 8'h01 | (8'(VEC[i].md) << 2));
      run_cycles(int'(VEC[i].ncyc));
      @(negedge clk);
      rd16(3'd0, v16); check($sformatf("R3/R5/R7/R9 vec%0d count", i), v16, VEC[i].exp_cnt);
      rd(3'd4, v8);    check($sformatf("R5/R7/R9 vec%0d ovf", i), 16'(v8[5]), 16'(VEC[i].exp_ovf));
      check($sformatf("R9 vec%0d baud pulses", i), 16'(pulses), 16'(VEC[i].exp_pulses));
    end

    // R3 run clear: no counting
    setup(16'h0000, 16'h0042);
    run_cycles(10);
    rd16(3'd0, v16); check("R3 halted", v16, 16'h0042);

    // R4 external count source
    setup(16'h0000, 16'h0000);
    wr(3'd4, 8'h03);
    begin
      logic [6:0] seq = 7'b0100101;  // pins 1,0,1,0,0,1,0 from bit 0
      for (int k = 0; k < 7; k++) begin
        tick_i = 1'b1; cnt_pin_i = seq[k];
        @(negedge clk);
      end
      tick_i = 1'b0; cnt_pin_i = 1'b0;
    end
    rd16(3'd0, v16); check("R4 ext falls", v16, 16'h0003);

    // R10 trigger disabled
    setup(16'h5555, 16'h0100);
    wr(3'd4, 8'h01);
    trig_seq();
    rd16(3'd2, v16); check("R10 rld kept", v16, 16'h5555);
    rd(3'd4, v8);    check("R10 exf", 16'(v8[6]), 16'h0);

    // R6 capture on trigger
    setup(16'h0000, 16'h0100);
    wr(3'd4, 8'h11);
    trig_seq();
    rd16(3'd2, v16); check("R6 captured", v16, 16'h0103);
    rd16(3'd0, v16); check("R6 count runs", v16, 16'h0104);
    check("R6 exf", 16'(ext_flag_o), 16'h1);

    // R8 reload on trigger with run clear
    setup(16'hABCD, 16'h0005);
    wr(3'd4, 8'h14);
    trig_seq();
    rd16(3'd0, v16); check("R8 reloaded", v16, 16'hABCD);
    rd(3'd4, v8);    check("R8 flags", 16'(v8[6:5]), 16'h2);

    // R11 write beats increment
    setup(16'h0000, 16'h0010);
    wr(3'd4, 8'h01);
    @(negedge clk);
    addr_i = 3'd0; wdata_i = 8'h77; wr_en_i = 1'b1; tick_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
    rd16(3'd0, v16); check("R11 write wins", v16, 16'h0077);

    // R12 flag write semantics
    setup(16'h0000, 16'hFFFF);
    wr(3'd4, 8'h01);
    run_cycles(1);
    wr(3'd4, 8'h20); rd(3'd4, v8); check("R12 write1 keeps", 16'(v8[5]), 16'h1);
    wr(3'd4, 8'h00); rd(3'd4, v8); check("R12 write0 clears", 16'(v8[5]), 16'h0);
    wr(3'd4, 8'h60); rd(3'd4, v8); check("R12 write1 no set", 16'(v8[6:5]), 16'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule